// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Output Unit

This block is an 8-bit up-counter that advances on a count-enable tick and compares its value against two constant registers, A and B. A match on either register acts on one registered output pin. For each register a 2-bit action field chooses the effect of a match: leave the pin alone, force it low, force it high, or invert it. When both registers match on the same tick, a fixed ranking decides the outcome.

A capture-enable control bit turns register B into a capture register. In that mode register B no longer drives the pin. Its action field selects which edge of an external capture input latches the running counter value. The capture input passes through a two-flop synchronizer before its edges are detected.

Software reaches the counter, both constant registers and the control register through a plain register port. A write takes effect at the next clock edge, and a read is combinational from the address. This port has no handshake and never back-pressures. The count tick, the capture input and the pin are plain control signals and carry no valid/ready pairing.

Top module: `dual_cmp_timer`

## Requirements
- R1: The counter increments by one at each clock edge where `cnt_tick` is 1, wrapping from 255 to 0, and holds when `cnt_tick` is 0. A register write to the counter takes precedence over the tick.
- R2: The register addresses are 0 = counter, 1 = constant A, 2 = constant B and 3 = control. The control bits are [1:0] = A action, [3:2] = B field and [4] = capture enable. Control bits above bit 4 read as zero, and every register reads back what was written.
- R3: The A action codes are 00 = no change, 01 = drive 0, 10 = drive 1 and 11 = invert. A code is applied at the clock edge of a tick on which the counter equals constant A. Without a tick, a match has no effect.
- R4: While capture enable is 0, the B field uses the same four codes on a tick where the counter equals constant B.
- R5: When A and B both match on one tick, the higher-ranked action is applied. The ranking is invert, then drive 1, then drive 0, then no change.
- R6: When control bits [3:0] are all zero, the pin holds its value across any number of ticks and matches.
- R7: After reset, the counter, both constants, the control register and the pin are all 0.
- R8: While capture enable is 1, a counter match with constant B never changes the pin.
- R9: While capture enable is 1, the B field selects the capture edge: 00 = none, 01 = rising, 10 = falling, 11 = both. A selected edge writes the counter into constant B two clock edges after the input change is first sampled. The counter value written is the one present at that edge. A capture takes precedence over a software write to B on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count enable; one counter step per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output pin |

## Verification
The two compare channels can both match on the same tick and ask for conflicting pin actions, and only the ranking settles the result. The bench provokes this by loading both constants and the counter with one value, then issuing a single tick. It sweeps all sixteen pairs of A and B action codes from both starting pin levels. Each resulting pin level is judged against the highest-ranked requested action, computed in the bench. Single-channel matches and the all-zero (disabled) setting fall out of the same sweep.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  localparam int ADDR_W    = 2;
  localparam int CTRL_W    = 5;
  localparam int NUM_CH    = 2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPB = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;
  localparam int CTRL_CAP_BIT = 4;
endpackage

// File: rtl/tmr_edge_capture.sv
module tmr_edge_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic       enable,
  input  logic [1:0] edge_sel,
  output logic       fire
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & last_q;
  // bit 0 selects rising, bit 1 selects falling
  assign fire = enable & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             tick,
  input  logic             enable,
  input  logic [1:0]       act,
  output pin_act_e         req
);
  always_comb begin
    req = ACT_NONE;
    if (enable && tick && (cnt == ref_val)) req = pin_act_e'(act);
  end
endmodule

// File: rtl/tmr_pin_resolve.sv
module tmr_pin_resolve
  import tmr_pkg::*;
#(
  parameter int NUM_REQ = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  out_en,
  input  logic [NUM_REQ-1:0][1:0] reqs,
  output logic                  pin
);
  pin_act_e win;

  // encodings rank numerically: invert > high > low > none
  always_comb begin
    win = ACT_NONE;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqs[i] > win) win = pin_act_e'(reqs[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else if (out_en) begin
      unique case (win)
        ACT_NONE:   pin <= pin;
        ACT_LOW:    pin <= 1'b0;
        ACT_HIGH:   pin <= 1'b1;
        ACT_TOGGLE: pin <= ~pin;
      endcase
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              cap_in,
  output logic              tmr_out
);
  logic [CNT_W-1:0]  cnt_q, cmp_a_q, cmp_b_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              cap_en, cap_fire, out_en;
  logic [NUM_CH-1:0][CNT_W-1:0] refs;
  logic [NUM_CH-1:0][1:0]       acts;
  logic [NUM_CH-1:0]            ch_en;
  logic [NUM_CH-1:0][1:0]       reqs;

  assign cap_en = ctrl_q[CTRL_CAP_BIT];
  assign out_en = |ctrl_q[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_en && wr_addr == ADDR_CNT) cnt_q <= wr_data;
    else if (cnt_tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_CMPA) cmp_a_q <= wr_data;
      if (cap_fire) cmp_b_q <= cnt_q;
      else if (wr_en && wr_addr == ADDR_CMPB) cmp_b_q <= wr_data;
      if (wr_en && wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_CNT:  rd_data = cnt_q;
      ADDR_CMPA: rd_data = cmp_a_q;
      ADDR_CMPB: rd_data = cmp_b_q;
      default:   rd_data = CNT_W'(ctrl_q);
    endcase
  end

  assign refs  = {cmp_b_q, cmp_a_q};
  assign acts  = {ctrl_q[3:2], ctrl_q[1:0]};
  assign ch_en = {~cap_en, 1'b1};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pin_act_e req_e;
    tmr_match_unit #(.CNT_W(CNT_W)) u_match (
      .cnt     (cnt_q),
      .ref_val (refs[g]),
      .tick    (cnt_tick),
      .enable  (ch_en[g]),
      .act     (acts[g]),
      .req     (req_e)
    );
    assign reqs[g] = req_e;
  end

  tmr_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_in   (cap_in),
    .enable   (cap_en),
    .edge_sel (ctrl_q[3:2]),
    .fire     (cap_fire)
  );

  tmr_pin_resolve #(.NUM_REQ(NUM_CH)) u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .out_en (out_en),
    .reqs   (reqs),
    .pin    (tmr_out)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b,
  input logic [4:0]       ctrl,
  input logic             cap_fire,
  input logic             tmr_out
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !(wr_en && wr_addr == 2'd0)) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !wr_en) |=> $stable(cnt_q));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(tmr_out));

  assert_toggle_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && cnt_q == cmp_a && ctrl[1:0] == 2'b11) |=> tmr_out != $past(tmr_out));

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:0] == 4'd0) |=> $stable(tmr_out));

  assert_capmode_b_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] && (cnt_q != cmp_a || ctrl[1:0] == 2'b00)) |=> $stable(tmr_out));

  assert_capture_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cmp_b == $past(cnt_q));
endmodule

bind dual_cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_tick (cnt_tick),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .cnt_q    (cnt_q),
  .cmp_a    (cmp_a_q),
  .cmp_b    (cmp_b_q),
  .ctrl     (ctrl_q),
  .cap_fire (cap_fire),
  .tmr_out  (tmr_out)
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cap_in = 1'b0;
  logic       tmr_out;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_cmp_timer u_dual_cmp_timer (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cap_in(cap_in), .tmr_out(tmr_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic set_pin(input bit v);
    wr(2'd3, v ? 8'h02 : 8'h01);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h40);
    tick_n(1);
  endtask

  function automatic bit expect_pin(input bit start, input int code);
    case (code)
      0: return start;
      1: return 1'b0;
      2: return 1'b1;
      default: return ~start;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(tmr_out == 1'b0, "R7 pin after reset", tmr_out, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'd0, "R7 register after reset", d, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: readback and control width
    wr(2'd1, 8'h5A); wr(2'd2, 8'hA5); wr(2'd3, 8'hFF);
    rd(2'd1, d); check(d == 8'h5A, "R2 constant A readback", d, 8'h5A);
    rd(2'd2, d); check(d == 8'hA5, "R2 constant B readback", d, 8'hA5);
    rd(2'd3, d); check(d == 8'h1F, "R2 control readback", d, 8'h1F);
    wr(2'd3, 8'h00);

    // R1: counting, wrap, hold
    wr(2'd0, 8'd250);
    tick_n(10);
    rd(2'd0, d); check(d == 8'd4, "R1 wrap 250+10", d, 4);
    repeat (5) @(negedge clk);
    rd(2'd0, d); check(d == 8'd4, "R1 hold without tick", d, 4);
    wr(2'd0, 8'd0);
    for (int k = 1; k <= 256; k += 51) begin
      wr(2'd0, 8'd0);
      tick_n(k);
      rd(2'd0, d); check(d == 8'(k), "R1 count sweep", d, k % 256);
    end

    // R3 R4 R5 R6: action sweep, both matching, A only, B only
    for (int sc = 0; sc < 3; sc++) begin
      for (int st = 0; st < 2; st++) begin
        for (int a = 0; a < 4; a++) begin
          for (int b = 0; b < 4; b++) begin
            int code;
            set_pin(st[0]);
            wr(2'd3, 8'((b << 2) | a));
            wr(2'd1, sc == 2 ? 8'h77 : 8'h33);
            wr(2'd2, sc == 1 ? 8'h77 : 8'h33);
            wr(2'd0, 8'h33);
            tick_n(1);
            code = (sc == 1) ? a : (sc == 2) ? b : ((a > b) ? a : b);
            if (sc == 0)
              check(tmr_out == expect_pin(st[0], code), "R5 simultaneous ranking",
                    tmr_out, expect_pin(st[0], code));
            else if (sc == 1)
              check(tmr_out == expect_pin(st[0], code), "R3 A-only action",
                    tmr_out, expect_pin(st[0], code));
            else
              check(tmr_out == expect_pin(st[0], code), "R4 B-only action",
                    tmr_out, expect_pin(st[0], code));
          end
        end
      end
    end

    // R3: match without tick does nothing
    set_pin(1'b0);
    wr(2'd3, 8'h03); wr(2'd1, 8'h10); wr(2'd0, 8'h10);
    repeat (4) @(negedge clk);
    check(tmr_out == 1'b0, "R3 no tick no action", tmr_out, 0);

    // R6: disabled over a full wrap
    set_pin(1'b1);
    wr(2'd3, 8'h00);
    tick_n(300);
    check(tmr_out == 1'b1, "R6 disabled holds", tmr_out, 1);

    // R8: capture mode, B match ignored
    set_pin(1'b1);
    wr(2'd2, 8'h20); wr(2'd0, 8'h20);
    wr(2'd3, 8'h1C);
    tick_n(1);
    check(tmr_out == 1'b1, "R8 B match ignored in capture mode", tmr_out, 1);
    rd(2'd2, d); check(d == 8'h20, "R8 B unchanged without edge", d, 8'h20);

    // R9: edge selection sweep with counter held
    for (int m = 0; m < 4; m++) begin
      for (int rise = 0; rise < 2; rise++) begin
        bit fires;
        logic [7:0] v;
        v = 8'(8'h60 + m * 2 + rise);
        wr(2'd3, 8'h00);
        @(negedge clk); cap_in = ~rise[0];
        repeat (4) @(negedge clk);
        wr(2'd2, 8'hEE);
        wr(2'd0, v);
        wr(2'd3, 8'(8'h10 | (m << 2)));
        cap_in = rise[0];
        repeat (5) @(negedge clk);
        fires = (m == 3) || (m == 1 && rise == 1) || (m == 2 && rise == 0);
        rd(2'd2, d);
        check(d == (fires ? v : 8'hEE), "R9 edge select", d, fires ? v : 8'hEE);
      end
    end

    // R9: capture latency with the counter running
    wr(2'd3, 8'h00);
    @(negedge clk); cap_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'd20);
    wr(2'd3, 8'h14);
    @(negedge clk);
    cap_in = 1'b1; cnt_tick = 1'b1;
    repeat (6) @(negedge clk);
    cnt_tick = 1'b0;
    rd(2'd2, d); check(d == 8'd22, "R9 capture latency value", d, 22);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule